// File: doc/BRIEF.md
# Accumulator-Stepped Noise Shift Register

The block produces a pseudo-random noise waveform from a 23-bit linear feedback shift register. A phase accumulator outside the block supplies one of its upper bits as a strobe. The register advances by one step each time that strobe goes from low to high, so the rate of the noise follows the oscillator frequency. A test input forces the register to zero. When test is released, the register is seeded with a fixed non-zero pattern, so the sequence always starts from a known point.

The output is a 12-bit sample. Eight scattered register bits are gathered into its upper byte, and its low nibble is zero. The sample is registered state only, so it changes in the cycle after a step takes effect.

Top module: `noise_lfsr`

## Requirements
- R1: After reset is asserted, the register holds 0x7FFFF8, and the output is 0xFE0.
- R2: A step computes a feedback bit equal to register bit 22 XOR register bit 17. It then shifts the register left by one place, drops bit 22 and puts the feedback bit into bit 0.
- R3: The register takes exactly one step in the cycle after strobe_i is sampled high when it was sampled low in the previous cycle. A strobe held high, or held low, causes no step.
- R4: While test_i is high, the register reads as zero from the next cycle on, and the output is 0x000.
- R5: In the cycle that test_i is sampled low after having been high, the register is loaded with 0x7FFFF8.
- R6: A strobe rising edge that arrives while test_i is high has no effect. After test is released, the register holds the seed until a later strobe edge.
- R7: Output bits 11 down to 4 are taken from register bits 22, 20, 16, 13, 11, 7, 4 and 2, in that order. Output bits 3:0 are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| test_i | input | 1 | Clears the register while high and seeds it on release |
| strobe_i | input | 1 | Bit 19 of the external phase accumulator |
| noise_o | output | 12 | Noise sample |
| state_o | output | 23 | Current register contents |

## Verification
The hardest case to reach is a strobe edge that arrives while test is high and the register is already zero. An edge that was wrongly taken there would leave the register at zero, which looks the same as an ignored edge. The stimulus therefore toggles the strobe during test and then releases test. The register must then hold exactly the seed until the next strobe edge, with no extra step. A long sweep of several thousand steps, against a bench model of the polynomial, covers the feedback and the output tap mapping.

// File: rtl/noise_lfsr_pkg.sv
package noise_lfsr_pkg;
  localparam int unsigned LFSR_W = 23;
  localparam int unsigned OUT_W  = 12;
  localparam int unsigned TAP_N  = 8;
  localparam logic [LFSR_W-1:0] SEED = 23'h7FFFF8;
  // output bit 7..0 source positions
  localparam int unsigned TAP_POS [TAP_N] = '{22, 20, 16, 13, 11, 7, 4, 2};

  typedef enum logic [1:0] {OP_HOLD, OP_STEP, OP_CLEAR, OP_SEED} lfsr_op_e;
endpackage

// File: rtl/noise_edge_det.sv
module noise_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  logic sig_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;
  assign rise_o = sig_i & ~sig_q;
endmodule

// File: rtl/noise_ctrl.sv
module noise_ctrl
  import noise_lfsr_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     test_i,
  input  logic     rise_i,
  output lfsr_op_e op_o
);
  logic test_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) test_q <= 1'b0;
    else         test_q <= test_i;

  // test dominates; release seeds; edge only when running
  always_comb begin
    if (test_i)      op_o = OP_CLEAR;
    else if (test_q) op_o = OP_SEED;
    else if (rise_i) op_o = OP_STEP;
    else             op_o = OP_HOLD;
  end
endmodule

// File: rtl/noise_tap_map.sv
module noise_tap_map
  import noise_lfsr_pkg::*;
(
  input  logic [LFSR_W-1:0] state_i,
  output logic [OUT_W-1:0]  noise_o
);
  localparam int unsigned PAD_W = OUT_W - TAP_N;
  for (genvar g = 0; g < TAP_N; g++) begin : g_tap
    assign noise_o[OUT_W-1-g] = state_i[TAP_POS[g]];
  end
  assign noise_o[PAD_W-1:0] = '0;
endmodule

// File: rtl/noise_lfsr.sv
module noise_lfsr
  import noise_lfsr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              test_i,
  input  logic              strobe_i,
  output logic [OUT_W-1:0]  noise_o,
  output logic [LFSR_W-1:0] state_o
);
  localparam int unsigned FB_A = LFSR_W - 1;
  localparam int unsigned FB_B = LFSR_W - 6;

  logic     rise;
  lfsr_op_e op;
  logic [LFSR_W-1:0] lfsr_q, lfsr_d;

  noise_edge_det u_edge (.clk_i, .rst_ni, .sig_i(strobe_i), .rise_o(rise));
  noise_ctrl     u_ctrl (.clk_i, .rst_ni, .test_i, .rise_i(rise), .op_o(op));

  always_comb begin
    unique case (op)
      OP_STEP:  lfsr_d = {lfsr_q[LFSR_W-2:0], lfsr_q[FB_A] ^ lfsr_q[FB_B]};
      OP_CLEAR: lfsr_d = '0;
      OP_SEED:  lfsr_d = SEED;
      default:  lfsr_d = lfsr_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) lfsr_q <= SEED;
    else         lfsr_q <= lfsr_d;

  noise_tap_map u_map (.state_i(lfsr_q), .noise_o);
  assign state_o = lfsr_q;

  a_r4_test_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_i |=> (state_o == '0));
  a_r5_release_seeds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(test_i) && !test_i) |=> (state_o == SEED));
  a_r3_hold_no_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!test_i && $past(!test_i) && !(strobe_i && !$past(strobe_i))) |=> $stable(state_o));
  a_r2_step_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!test_i && $past(!test_i) && strobe_i && !$past(strobe_i)) |=>
      (state_o == {$past(state_o[LFSR_W-2:0]), $past(state_o[FB_A]) ^ $past(state_o[FB_B])}));
  a_r7_low_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    noise_o[3:0] == 4'h0);
endmodule

// File: tb/noise_lfsr_test.sv
module noise_lfsr_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic test = 1'b0;
  logic strobe = 1'b0;
  logic [11:0] noise;
  logic [22:0] state;
  logic [22:0] model;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  noise_lfsr uut (.clk_i(clk), .rst_ni(rst_n), .test_i(test), .strobe_i(strobe),
                  .noise_o(noise), .state_o(state));

  function automatic logic [11:0] exp_noise(logic [22:0] s);
    return {s[22], s[20], s[16], s[13], s[11], s[7], s[4], s[2], 4'h0};
  endfunction

  function automatic logic [22:0] step(logic [22:0] s);
    return {s[21:0], s[22] ^ s[17]};
  endfunction

  task automatic chk(string req, logic [22:0] exp_s);
    checks++;
    if (state !== exp_s || noise !== exp_noise(exp_s)) begin
      errors++;
      $display("FAIL %s state %h noise %h expected state %h noise %h",
               req, state, noise, exp_s, exp_noise(exp_s));
    end
  endtask

  // drive after posedge, sample before next
  task automatic cyc(logic t, logic s);
    @(posedge clk); #1; test = t; strobe = s;
    @(posedge clk); #4;
  endtask

  initial begin
    #200000000;
    errors++;
    $display("FAIL watchdog expired state %h expected finish", state);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #23;
    chk("R1 reset", 23'h7FFFF8);
    checks++;
    if (noise !== 12'hFE0) begin errors++; $display("FAIL R1 noise %h expected fe0", noise); end
    rst_n = 1'b1;
    model = 23'h7FFFF8;
    cyc(0, 1); model = step(model); chk("R2 R3 first step", model);
    cyc(0, 1); chk("R3 held high no step", model);
    cyc(0, 0); chk("R3 fall no step", model);
    cyc(0, 0); chk("R3 low no step", model);
    for (int i = 0; i < 6000; i++) begin
      cyc(0, 1); model = step(model); chk("R2 R7 sweep", model);
      cyc(0, 0); chk("R3 sweep fall", model);
    end
    cyc(1, 0); chk("R4 test clears", 23'h0);
    cyc(1, 1); chk("R6 edge during test", 23'h0);
    cyc(1, 0); chk("R4 held", 23'h0);
    cyc(1, 1); chk("R6 edge during test 2", 23'h0);
    cyc(0, 1); model = 23'h7FFFF8; chk("R5 R6 release seeds", model);
    cyc(0, 1); chk("R6 seed held", model);
    cyc(0, 0); chk("R6 seed held low", model);
    cyc(0, 1); model = step(model); chk("R2 step after seed", model);
    // release coincident with rising edge: seed wins
    cyc(1, 0); chk("R4 clear again", 23'h0);
    cyc(0, 1); model = 23'h7FFFF8; chk("R5 release with edge", model);
    cyc(0, 0); chk("R6 no late step", model);
    for (int i = 0; i < 300; i++) begin
      cyc(0, 1); model = step(model); chk("R2 R7 sweep2", model);
      cyc(0, 0);
    end
    checks++;
    if (noise[3:0] !== 4'h0) begin errors++; $display("FAIL R7 low nibble %h expected 0", noise[3:0]); end
    rst_n = 1'b0; #3;
    chk("R1 async reset", 23'h7FFFF8);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule